// File: doc/BRIEF.md
# Separate-Port Burst-Four Double-Rate SRAM

This block is a synthesizable on-chip memory with a read port and a write port that share one address bus. Every accepted command moves a burst of four words. Two words move in each clock cycle. The even beat and the odd beat of a cycle appear side by side on the data buses, in place of a half-cycle clock. On every rising edge the block samples the address, the active-low read and write strobes, the write data and the byte enables. It then accepts or ignores each strobe according to the burst state of that strobe's own port.

The two ports run independently, so a system can alternate reads and writes with both data buses busy. Each port ignores its own strobe in the cycle that directly follows one of its accepted commands. The second half of that burst occupies that cycle. Burst addresses wrap inside the aligned group of four words. A valid flag marks the cycles that carry read data.

Top module: `sqb_burst_sram`

## Requirements
- R1: After reset, `q_valid` is low, `q_even` and `q_odd` are zero, and no write burst is pending.
- R2: If `rd_n` is low on an edge and no read burst is half done, the read is accepted. In the next cycle `q_even`/`q_odd` carry words A and A+1. In the cycle after that they carry A+2 and A+3. `q_valid` is high in both cycles.
- R3: A low `rd_n` on the edge directly after an accepted read is ignored, and that burst's second pair is delivered unchanged. A read on the edge after that is accepted, so `q_valid` stays high without a gap.
- R4: If `rd_n` is high on an edge and no read burst is half done, `q_valid` is low in the following cycle.
- R5: While `q_valid` is low, `q_even` and `q_odd` are all zeros.
- R6: If `wr_n` is low on an edge, the write is accepted unless it falls in a lockout cycle. `d_even`/`d_odd` on the next edge are written to C and C+1. On the edge after that they are written to C+2 and C+3.
- R7: A low `wr_n` on the edge directly after an accepted write is ignored. The data sampled on that edge belongs to the earlier burst. A write on the following edge is accepted.
- R8: Bit i of `be_even`/`be_odd` enables data bits [9i+8:9i] of the matching beat. A byte whose bit is 0 keeps its stored value.
- R9: The burst address keeps the upper address bits and adds the beat index 0..3 to the two low bits modulo 4. A burst at an address whose low bits are 2 visits offsets 2, 3, 0, 1.
- R10: A command on one port never changes a burst in progress on the other port. Reads and writes may be accepted on adjacent edges or on the same edge.
- R11: With `rd_n` and `wr_n` both high, and no burst pending, nothing is written and no read data appears. This holds whatever the data and byte-enable inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Burst start address for either port |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| d_even | input | DATA_W | Write data, even beat of the cycle |
| d_odd | input | DATA_W | Write data, odd beat of the cycle |
| be_even | input | DATA_W/BYTE_W | Byte enables for `d_even`, active high |
| be_odd | input | DATA_W/BYTE_W | Byte enables for `d_odd`, active high |
| q_even | output | DATA_W | Read data, even beat of the cycle |
| q_odd | output | DATA_W | Read data, odd beat of the cycle |
| q_valid | output | 1 | High in cycles that carry read data |

## Verification
The bench uses the default build: 256 words of 18 bits with two 9-bit byte lanes. With this build, each lane can be masked on its own and both lane positions are covered by the byte-enable checks. The 8-bit address lets bursts start at every low-bit offset, so the wrap order is observed at offsets 2 and 3. Several disjoint four-word groups stay apart, so a write aimed at the wrong group shows up on read-back.

// File: rtl/sqb_pkg.sv
package sqb_pkg;

    localparam int BURST_BEATS = 4;
    localparam int BEATS_PER_CYCLE = 2;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_FIRST  = 2'd1,
        WR_SECOND = 2'd2
    } wr_stage_e;

endpackage

// File: rtl/sqb_rd_seq.sv
module sqb_rd_seq #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] mem_addr0,
    output logic [ADDR_W-1:0] mem_addr1,
    input  logic [DATA_W-1:0] mem_rdata0,
    input  logic [DATA_W-1:0] mem_rdata1,
    output logic [DATA_W-1:0] q_even,
    output logic [DATA_W-1:0] q_odd,
    output logic              q_valid,
    output logic              second_pending
);

    typedef struct packed {
        logic              second;
        logic [ADDR_W-1:0] base;
        logic              valid;
        logic [DATA_W-1:0] qe;
        logic [DATA_W-1:0] qo;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic      accept;

    function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] b,
                                                     input logic [1:0] k);
        return {b[ADDR_W-1:2], b[1:0] + k};
    endfunction

    always_comb begin
        s_d       = s_q;
        accept    = !rd_n && !s_q.second;
        mem_addr0 = burst_addr(addr, 2'd0);
        mem_addr1 = burst_addr(addr, 2'd1);
        s_d.second = 1'b0;
        s_d.valid  = 1'b0;
        s_d.qe     = '0;
        s_d.qo     = '0;
        if (accept) begin
            s_d.second = 1'b1;
            s_d.base   = addr;
            s_d.valid  = 1'b1;
            s_d.qe     = mem_rdata0;
            s_d.qo     = mem_rdata1;
        end else if (s_q.second) begin
            mem_addr0 = burst_addr(s_q.base, 2'd2);
            mem_addr1 = burst_addr(s_q.base, 2'd3);
            s_d.valid = 1'b1;
            s_d.qe    = mem_rdata0;
            s_d.qo    = mem_rdata1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_even         = s_q.qe;
    assign q_odd          = s_q.qo;
    assign q_valid        = s_q.valid;
    assign second_pending = s_q.second;

endmodule

// File: rtl/sqb_wr_seq.sv
module sqb_wr_seq
    import sqb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9,
    localparam int NBE   = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_even,
    input  logic [DATA_W-1:0] d_odd,
    input  logic [NBE-1:0]    be_even,
    input  logic [NBE-1:0]    be_odd,
    output logic [ADDR_W-1:0] waddr0,
    output logic [ADDR_W-1:0] waddr1,
    output logic [DATA_W-1:0] wdata0,
    output logic [DATA_W-1:0] wdata1,
    output logic [NBE-1:0]    we0,
    output logic [NBE-1:0]    we1,
    output logic [1:0]        stage_o
);

    typedef struct packed {
        wr_stage_e         stage;
        logic [ADDR_W-1:0] base;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      accept;

    function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] b,
                                                     input logic [1:0] k);
        return {b[ADDR_W-1:2], b[1:0] + k};
    endfunction

    always_comb begin
        s_d    = s_q;
        we0    = '0;
        we1    = '0;
        waddr0 = burst_addr(s_q.base, 2'd0);
        waddr1 = burst_addr(s_q.base, 2'd1);
        accept = !wr_n && (s_q.stage != WR_FIRST);
        case (s_q.stage)
            WR_FIRST: begin
                we0 = be_even;
                we1 = be_odd;
            end
            WR_SECOND: begin
                waddr0 = burst_addr(s_q.base, 2'd2);
                waddr1 = burst_addr(s_q.base, 2'd3);
                we0    = be_even;
                we1    = be_odd;
            end
            default: ;
        endcase
        if (accept) begin
            s_d.stage = WR_FIRST;
            s_d.base  = addr;
        end else if (s_q.stage == WR_FIRST) begin
            s_d.stage = WR_SECOND;
        end else begin
            s_d.stage = WR_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wdata0  = d_even;
    assign wdata1  = d_odd;
    assign stage_o = s_q.stage;

endmodule

// File: rtl/sqb_mem_array.sv
module sqb_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9,
    localparam int NBE   = DATA_W / BYTE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] waddr0,
    input  logic [ADDR_W-1:0] waddr1,
    input  logic [DATA_W-1:0] wdata0,
    input  logic [DATA_W-1:0] wdata1,
    input  logic [NBE-1:0]    we0,
    input  logic [NBE-1:0]    we1,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [DATA_W-1:0] rdata0,
    output logic [DATA_W-1:0] rdata1
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Both beats of a cycle target distinct words of one aligned group.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBE; b++) begin
            if (we0[b]) mem[waddr0][b*BYTE_W +: BYTE_W] <= wdata0[b*BYTE_W +: BYTE_W];
            if (we1[b]) mem[waddr1][b*BYTE_W +: BYTE_W] <= wdata1[b*BYTE_W +: BYTE_W];
        end
    end

    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];

endmodule

// File: rtl/sqb_burst_sram.sv
module sqb_burst_sram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9,
    localparam int NBE   = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] d_even,
    input  logic [DATA_W-1:0] d_odd,
    input  logic [NBE-1:0]    be_even,
    input  logic [NBE-1:0]    be_odd,
    output logic [DATA_W-1:0] q_even,
    output logic [DATA_W-1:0] q_odd,
    output logic              q_valid
);

    logic [ADDR_W-1:0] raddr0_w, raddr1_w, waddr0_w, waddr1_w;
    logic [DATA_W-1:0] rdata0_w, rdata1_w, wdata0_w, wdata1_w;
    logic [NBE-1:0]    we0_w, we1_w;
    logic              rd_second_w;
    logic [1:0]        wr_stage_w;

    sqb_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .addr(addr),
        .mem_addr0(raddr0_w), .mem_addr1(raddr1_w),
        .mem_rdata0(rdata0_w), .mem_rdata1(rdata1_w),
        .q_even(q_even), .q_odd(q_odd), .q_valid(q_valid),
        .second_pending(rd_second_w)
    );

    sqb_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr),
        .d_even(d_even), .d_odd(d_odd), .be_even(be_even), .be_odd(be_odd),
        .waddr0(waddr0_w), .waddr1(waddr1_w),
        .wdata0(wdata0_w), .wdata1(wdata1_w),
        .we0(we0_w), .we1(we1_w), .stage_o(wr_stage_w)
    );

    sqb_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk),
        .waddr0(waddr0_w), .waddr1(waddr1_w),
        .wdata0(wdata0_w), .wdata1(wdata1_w),
        .we0(we0_w), .we1(we1_w),
        .raddr0(raddr0_w), .raddr1(raddr1_w),
        .rdata0(rdata0_w), .rdata1(rdata1_w)
    );

endmodule

// File: rtl/sqb_burst_sram_chk.sv
module sqb_burst_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              q_valid,
    input logic [DATA_W-1:0] q_even,
    input logic [DATA_W-1:0] q_odd,
    input logic              rd_second,
    input logic [1:0]        wr_stage
);

    logic run_odd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_odd <= 1'b0;
        else if (q_valid) run_odd <= ~run_odd;
        else              run_odd <= 1'b0;
    end

    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q_even == '0 && q_odd == '0));

    p_read_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !rd_second) |=> q_valid);

    p_pairs_whole_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_valid && $past(q_valid)) |-> !run_odd);

    p_read_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_second |=> (q_valid && !rd_second));

    p_read_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && !rd_second) |=> !q_valid);

    p_write_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stage == 2'd1) |=> (wr_stage == 2'd2));

endmodule

bind sqb_burst_sram sqb_burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .q_valid(q_valid),
    .q_even(q_even), .q_odd(q_odd),
    .rd_second(rd_second_w), .wr_stage(wr_stage_w)
);

// File: tb/sim_sqb_burst_sram.sv
module sim_sqb_burst_sram;
    localparam int AW = 8, DW = 18, BW = 9, NB = DW / BW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          rd_n, wr_n;
    logic [DW-1:0] d_even, d_odd;
    logic [NB-1:0] be_even, be_odd;
    logic [DW-1:0] q_even, q_odd;
    logic          q_valid;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] mdl [1<<AW];

    sqb_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .d_even(d_even), .d_odd(d_odd), .be_even(be_even), .be_odd(be_odd),
        .q_even(q_even), .q_odd(q_odd), .q_valid(q_valid)
    );

    function automatic logic [AW-1:0] wa(input logic [AW-1:0] b, input int k);
        return {b[AW-1:2], 2'(b[1:0] + 2'(k))};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                            input logic [DW-1:0] new_v,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r = old_v;
        for (int i = 0; i < NB; i++) if (be[i]) r[i*BW +: BW] = new_v[i*BW +: BW];
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] ee, input logic [DW-1:0] eo,
                         input logic ev);
        n_chk++;
        if ({q_valid, q_even, q_odd} !== {ev, ee, eo}) begin
            n_bad++;
            $display("FAIL %s: got v=%0b %h %h, expected v=%0b %h %h",
                     tag, q_valid, q_even, q_odd, ev, ee, eo);
        end
    endtask

    task automatic expect_pair(input string tag, input logic [DW-1:0] ee, input logic [DW-1:0] eo);
        check(tag, ee, eo, 1'b1);
    endtask

    task automatic expect_none(input string tag);
        check(tag, '0, '0, 1'b0);
    endtask

    task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] de, input logic [DW-1:0] dod,
                        input logic [NB-1:0] bee, input logic [NB-1:0] beo);
        rd_n = r; wr_n = w; addr = a;
        d_even = de; d_odd = dod; be_even = bee; be_odd = beo;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b1, '0, '0, '0, '0, '0);
    endtask

    task automatic wr_burst(input logic [AW-1:0] a,
                            input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                            input logic [DW-1:0] w2, input logic [DW-1:0] w3,
                            input logic [NB-1:0] m0, input logic [NB-1:0] m1,
                            input logic [NB-1:0] m2, input logic [NB-1:0] m3);
        step(1'b1, 1'b0, a, '0, '0, '0, '0);
        step(1'b1, 1'b1, '0, w0, w1, m0, m1);
        step(1'b1, 1'b1, '0, w2, w3, m2, m3);
        mdl[wa(a,0)] = merge(mdl[wa(a,0)], w0, m0);
        mdl[wa(a,1)] = merge(mdl[wa(a,1)], w1, m1);
        mdl[wa(a,2)] = merge(mdl[wa(a,2)], w2, m2);
        mdl[wa(a,3)] = merge(mdl[wa(a,3)], w3, m3);
    endtask

    task automatic rd_burst(input string tag, input logic [AW-1:0] a);
        step(1'b0, 1'b1, a, '0, '0, '0, '0);
        expect_pair({tag, " pair0"}, mdl[wa(a,0)], mdl[wa(a,1)]);
        idle();
        expect_pair({tag, " pair1"}, mdl[wa(a,2)], mdl[wa(a,3)]);
        idle();
        expect_none({tag, " after"});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        rd_n = 1'b1; wr_n = 1'b1; addr = '0;
        d_even = '0; d_odd = '0; be_even = '0; be_odd = '0;
        repeat (3) @(negedge clk);
        expect_none("R1 reset outputs");
        rst_n = 1'b1;
        idle();
        expect_none("R1 idle after reset");
        idle();
        expect_none("R5 zero bus while idle");
    endtask

    task automatic t_basic();
        wr_burst(8'h10, 18'h0A101, 18'h0B102, 18'h0C103, 18'h0D104, 2'b11, 2'b11, 2'b11, 2'b11);
        rd_burst("R2 R6 basic read of written burst", 8'h10);
    endtask

    task automatic t_wrap();
        wr_burst(8'h22, 18'h12222, 18'h12323, 18'h12020, 18'h12121, 2'b11, 2'b11, 2'b11, 2'b11);
        step(1'b0, 1'b1, 8'h20, '0, '0, '0, '0);
        expect_pair("R9 wrap offset0 pair0", 18'h12020, 18'h12121);
        idle();
        expect_pair("R9 wrap offset0 pair1", 18'h12222, 18'h12323);
        step(1'b0, 1'b1, 8'h23, '0, '0, '0, '0);
        expect_pair("R9 wrap offset3 pair0", 18'h12323, 18'h12020);
        idle();
        expect_pair("R9 wrap offset3 pair1", 18'h12121, 18'h12222);
        idle();
        expect_none("R9 wrap done");
    endtask

    task automatic t_mask();
        wr_burst(8'h30, 18'h11111, 18'h22222, 18'h33333, 18'h04444, 2'b11, 2'b11, 2'b11, 2'b11);
        wr_burst(8'h30, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b10, 2'b00, 2'b11);
        step(1'b0, 1'b1, 8'h30, '0, '0, '0, '0);
        expect_pair("R8 masked lanes pair0", {9'h088, 9'h1FF}, {9'h1FF, 9'h022});
        idle();
        expect_pair("R8 masked lanes pair1", 18'h33333, 18'h3FFFF);
        idle();
        expect_none("R8 done");
    endtask

    task automatic t_rd_lock();
        step(1'b0, 1'b1, 8'h10, '0, '0, '0, '0);
        expect_pair("R3 first read pair0", mdl[8'h10], mdl[8'h11]);
        step(1'b0, 1'b1, 8'h20, '0, '0, '0, '0);
        expect_pair("R3 locked read ignored", mdl[8'h12], mdl[8'h13]);
        step(1'b0, 1'b1, 8'h30, '0, '0, '0, '0);
        expect_pair("R3 back-to-back read pair0", mdl[8'h30], mdl[8'h31]);
        idle();
        expect_pair("R3 back-to-back read pair1", mdl[8'h32], mdl[8'h33]);
        idle();
        expect_none("R4 read deselect");
    endtask

    task automatic t_wr_lock();
        wr_burst(8'h10, 18'h00510, 18'h00511, 18'h00512, 18'h00513, 2'b11, 2'b11, 2'b11, 2'b11);
        step(1'b1, 1'b0, 8'h40, '0, '0, '0, '0);
        step(1'b1, 1'b0, 8'h10, 18'h04040, 18'h04141, 2'b11, 2'b11);
        step(1'b1, 1'b0, 8'h54, 18'h04242, 18'h04343, 2'b11, 2'b11);
        step(1'b1, 1'b1, '0, 18'h05454, 18'h05555, 2'b11, 2'b11);
        step(1'b1, 1'b1, '0, 18'h05656, 18'h05757, 2'b11, 2'b11);
        mdl[8'h40] = 18'h04040; mdl[8'h41] = 18'h04141;
        mdl[8'h42] = 18'h04242; mdl[8'h43] = 18'h04343;
        mdl[8'h54] = 18'h05454; mdl[8'h55] = 18'h05555;
        mdl[8'h56] = 18'h05656; mdl[8'h57] = 18'h05757;
        rd_burst("R7 locked write left target unchanged", 8'h10);
        rd_burst("R7 R6 first write took lockout data", 8'h40);
        rd_burst("R7 write after lockout accepted", 8'h54);
    endtask

    task automatic t_alternate();
        step(1'b0, 1'b1, 8'h10, '0, '0, '0, '0);
        expect_pair("R10 read A pair0", mdl[8'h10], mdl[8'h11]);
        idle();
        expect_pair("R10 read A pair1", mdl[8'h12], mdl[8'h13]);
        step(1'b0, 1'b1, 8'h20, '0, '0, '0, '0);
        expect_pair("R10 read B pair0", mdl[8'h20], mdl[8'h21]);
        step(1'b1, 1'b0, 8'h60, '0, '0, '0, '0);
        expect_pair("R10 read B pair1 beside write C", mdl[8'h22], mdl[8'h23]);
        step(1'b0, 1'b1, 8'h30, 18'h06060, 18'h06161, 2'b11, 2'b11);
        expect_pair("R10 read D pair0", mdl[8'h30], mdl[8'h31]);
        step(1'b1, 1'b0, 8'h70, 18'h06262, 18'h06363, 2'b11, 2'b11);
        expect_pair("R10 read D pair1 beside write E", mdl[8'h32], mdl[8'h33]);
        step(1'b1, 1'b1, '0, 18'h07070, 18'h07171, 2'b11, 2'b11);
        expect_none("R10 no read data");
        step(1'b1, 1'b1, '0, 18'h07272, 18'h07373, 2'b11, 2'b11);
        expect_none("R10 no read data 2");
        mdl[8'h60] = 18'h06060; mdl[8'h61] = 18'h06161;
        mdl[8'h62] = 18'h06262; mdl[8'h63] = 18'h06363;
        mdl[8'h70] = 18'h07070; mdl[8'h71] = 18'h07171;
        mdl[8'h72] = 18'h07272; mdl[8'h73] = 18'h07373;
        rd_burst("R10 write C stored", 8'h60);
        rd_burst("R10 write E stored", 8'h70);
    endtask

    task automatic t_deselect();
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b1, 8'h10, 18'h3ABCD, 18'h3DCBA, 2'b11, 2'b11);
            expect_none("R11 deselect no read");
        end
        rd_burst("R11 deselect left memory unchanged", 8'h10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_mask();
        t_rd_lock();
        t_wr_lock();
        t_alternate();
        t_deselect();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule